// File: doc/BRIEF.md
# Six-Stage In-Order Pipeline Sequencer

This block is the sequencing control for an in-order pipeline of six stages: instruction fetch, decode, operand-address calculation, operand fetch, execute and write-back. It carries no datapath. Each instruction is an opaque tag that moves one stage per clock, and each stage has a valid bit. In steady state one new tag enters fetch on every clock. The block tells the fetch unit when it may access memory, and it issues a redirect when a branch resolves as taken.

Fetch is blocked in a cycle where the instruction in operand fetch needs the single shared memory port. The older instruction gets the port, and a bubble enters the pipe behind it. A fetch-ready strobe that stays low also leaves a bubble. A taken branch is known only when it is in execute. In that case every younger instruction is dropped, the branch goes on to write-back, and fetch restarts at the target tag on the next clock.

Two free-running counters support performance measurement. One counts retired instructions and the other counts clocks, so the clocks per instruction equal one plus the average number of stall cycles.

Top module: `pipe6_sequencer`

## Requirements
- R1: While reset is asserted and immediately after it is released, every bit of `stageValid` is 0, `fetchTag` is 0, and both `retiredCount` and `cycleCount` are 0.
- R2: `stageValid` bit i belongs to stage i, with 0 = fetch, 1 = decode, 2 = operand address, 3 = operand fetch, 4 = execute and 5 = write-back. With `fetchReady` high every clock and no conflict or branch, one tag enters fetch per clock, `fetchTag` rises by one per clock, and the tag fetched at a given edge appears on `wbTag` five edges later.
- R3: A clock edge where `fetchReady` is low loads a bubble (valid 0) into the fetch stage and leaves `fetchTag` unchanged. All older stages still advance by one.
- R4: When `memConflict` is high while stage 3 is valid, `fetchEn` is 0 and `fetchStall` is 1 in that cycle. No tag is fetched at the next edge, and older stages still advance.
- R5: `memConflict` has no effect while stage 3 is empty: `fetchEn` stays 1 and fetch proceeds.
- R6: `redirect` is 1 in the same cycle that `branchTaken` is high while stage 4 is valid, and `redirectTag` then equals `branchTarget`.
- R7: On the edge that ends a redirect cycle, stages 0 to 4 become empty, the branch moves into write-back, and `fetchTag` loads the target. The target tag is fetched on the following edge.
- R8: `branchTaken` has no effect while stage 4 is empty: no redirect occurs and `fetchTag` keeps counting.
- R9: `retiredCount` increases by one on each edge where stage 5 is valid. `cycleCount` increases by one on every edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchReady | input | 1 | Instruction memory can return a word this cycle |
| memConflict | input | 1 | Operand fetch requests the shared memory port |
| branchTaken | input | 1 | Instruction in execute is a taken branch |
| branchTarget | input | TAG_W | Tag at which fetch restarts |
| stageValid | output | 6 | Valid bit of each stage, fetch in bit 0 |
| fetchEn | output | 1 | Fetch may use the memory port this cycle |
| fetchStall | output | 1 | No tag will enter fetch at the next edge |
| fetchTag | output | TAG_W | Tag of the next instruction to fetch |
| redirect | output | 1 | Flush younger stages and restart fetch |
| redirectTag | output | TAG_W | Restart tag during a redirect |
| wbTag | output | TAG_W | Tag currently in write-back |
| retiredCount | output | CNT_W | Valid write-backs since reset |
| cycleCount | output | CNT_W | Clocks since reset |

## Verification
A continuous fill shows the one-per-clock overlap, the five-edge tag latency and the retire count against elapsed clocks. A single low cycle on fetch-ready is compared with a conflict while operand fetch is occupied. Both insert a bubble without stopping the older stages, but only the conflict drops the fetch enable. The same conflict input is also applied with operand fetch empty, to show that it is gated by that stage's occupancy. A taken branch with execute full is compared with one raised on an empty pipe. The first case must empty every younger stage, retire the branch and refill from the target. The second case must change nothing.

// File: rtl/pipe6_pkg.sv
package pipe6_pkg;
  localparam int NSTG   = 6;
  localparam int STG_IF = 0;
  localparam int STG_ID = 1;
  localparam int STG_CO = 2;
  localparam int STG_FO = 3;
  localparam int STG_EX = 4;
  localparam int STG_WB = 5;

  typedef struct packed {
    logic advanceFetch;
    logic flushYoung;
    logic loadTarget;
    logic retire;
  } seqStrobes_t;
endpackage

// File: rtl/pipe6_ctrl.sv
module pipe6_ctrl
  import pipe6_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSTG-1:0] vldIn,
  input  logic            fetchReady,
  input  logic            memConflict,
  input  logic            branchTaken,
  output seqStrobes_t     strb,
  output logic            fetchEn,
  output logic            fetchStall,
  output logic            redirect
);
  logic portClash;

  always_comb begin
    portClash         = memConflict & vldIn[STG_FO];
    redirect          = branchTaken & vldIn[STG_EX];
    fetchEn           = ~portClash;
    strb.advanceFetch = fetchEn & fetchReady & ~redirect;
    strb.flushYoung   = redirect;
    strb.loadTarget   = redirect;
    strb.retire       = vldIn[STG_WB];
    fetchStall        = ~strb.advanceFetch;
  end

  AST_FLUSH_EMPTIES_YOUNG: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> (vldIn[STG_EX:STG_IF] == '0)); // R7
  AST_CLASH_BLOCKS_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    (memConflict && vldIn[STG_FO]) |=> !vldIn[STG_IF]); // R4
endmodule

// File: rtl/pipe6_datapath.sv
module pipe6_datapath
  import pipe6_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strb,
  input  logic [TAG_W-1:0] branchTarget,
  output logic [NSTG-1:0]  vld,
  output logic [TAG_W-1:0] fetchTag,
  output logic [TAG_W-1:0] wbTag,
  output logic [CNT_W-1:0] retired,
  output logic [CNT_W-1:0] cycles
);
  logic [TAG_W-1:0] stgTag [NSTG];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vld <= '0;
      for (int s = 0; s < NSTG; s++) stgTag[s] <= '0;
    end else begin
      vld[STG_IF]    <= strb.advanceFetch;
      stgTag[STG_IF] <= fetchTag;
      for (int s = 1; s < NSTG; s++) begin
        if (strb.flushYoung && s <= STG_EX) vld[s] <= 1'b0;
        else                                vld[s] <= vld[s-1];
        stgTag[s] <= stgTag[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  fetchTag <= '0;
    else if (strb.loadTarget)   fetchTag <= branchTarget;
    else if (strb.advanceFetch) fetchTag <= fetchTag + TAG_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      retired <= '0;
      cycles  <= '0;
    end else begin
      retired <= retired + CNT_W'(strb.retire);
      cycles  <= cycles + CNT_W'(1);
    end
  end

  assign wbTag = stgTag[STG_WB];

  AST_RETIRE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    vld[STG_WB] |=> (retired == $past(retired) + CNT_W'(1))); // R9
  AST_TAG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.advanceFetch || strb.loadTarget) |=> $stable(fetchTag)); // R3
  AST_EX_REACHES_WB: assert property (@(posedge clk) disable iff (!rstN)
    vld[STG_EX] |=> vld[STG_WB]); // R7
endmodule

// File: rtl/pipe6_sequencer.sv
module pipe6_sequencer
  import pipe6_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fetchReady,
  input  logic             memConflict,
  input  logic             branchTaken,
  input  logic [TAG_W-1:0] branchTarget,
  output logic [5:0]       stageValid,
  output logic             fetchEn,
  output logic             fetchStall,
  output logic [TAG_W-1:0] fetchTag,
  output logic             redirect,
  output logic [TAG_W-1:0] redirectTag,
  output logic [TAG_W-1:0] wbTag,
  output logic [CNT_W-1:0] retiredCount,
  output logic [CNT_W-1:0] cycleCount
);
  seqStrobes_t     strb;
  logic [NSTG-1:0] vld;

  pipe6_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .vldIn       (vld),
    .fetchReady  (fetchReady),
    .memConflict (memConflict),
    .branchTaken (branchTaken),
    .strb        (strb),
    .fetchEn     (fetchEn),
    .fetchStall  (fetchStall),
    .redirect    (redirect)
  );

  pipe6_datapath #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .branchTarget (branchTarget),
    .vld          (vld),
    .fetchTag     (fetchTag),
    .wbTag        (wbTag),
    .retired      (retiredCount),
    .cycles       (cycleCount)
  );

  assign stageValid  = vld;
  assign redirectTag = branchTarget;
endmodule

// File: tb/pipe6_sequencer_bench.sv
`timescale 1ns/1ps
module pipe6_sequencer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReady = 1'b0, memConflict = 1'b0, branchTaken = 1'b0;
  logic [7:0]  branchTarget = '0;
  logic [5:0]  stageValid;
  logic        fetchEn, fetchStall, redirect;
  logic [7:0]  fetchTag, redirectTag, wbTag;
  logic [15:0] retiredCount, cycleCount;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  pipe6_sequencer u_pipe6_sequencer (
    .clk(clk), .rstN(rstN), .fetchReady(fetchReady), .memConflict(memConflict),
    .branchTaken(branchTaken), .branchTarget(branchTarget), .stageValid(stageValid),
    .fetchEn(fetchEn), .fetchStall(fetchStall), .fetchTag(fetchTag),
    .redirect(redirect), .redirectTag(redirectTag), .wbTag(wbTag),
    .retiredCount(retiredCount), .cycleCount(cycleCount)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; fetchReady = 0; memConflict = 0; branchTaken = 0; branchTarget = '0;
    step(2);
    rstN = 1'b1;
  endtask

  task automatic testReset();
    doReset();
    check("R1 stageValid", 32'(stageValid), 0);
    check("R1 fetchTag", 32'(fetchTag), 0);
    check("R1 retiredCount", 32'(retiredCount), 0);
    check("R1 cycleCount", 32'(cycleCount), 0);
  endtask

  task automatic testFill();
    doReset();
    fetchReady = 1;
    step(10);
    check("R2 full", 32'(stageValid), 32'h3f);
    check("R2 fetchTag", 32'(fetchTag), 10);
    check("R2 wbTag", 32'(wbTag), 4);
    check("R9 retired", 32'(retiredCount), 4);
    check("R9 cycles", 32'(cycleCount), 10);
  endtask

  task automatic testBubble();
    doReset();
    fetchReady = 1;
    step(8);
    fetchReady = 0;
    step(1);
    check("R3 bubble in fetch", 32'(stageValid), 32'h3e);
    check("R3 tag held", 32'(fetchTag), 8);
    fetchReady = 1;
    step(1);
    check("R3 bubble in decode", 32'(stageValid), 32'h3d);
    check("R3 tag resumes", 32'(fetchTag), 9);
    step(4);
    check("R3 bubble at wb", 32'(stageValid), 32'h1f);
  endtask

  task automatic testClash();
    doReset();
    fetchReady = 1;
    step(4);
    memConflict = 1;
    #1;
    check("R4 fetchEn", 32'(fetchEn), 0);
    check("R4 fetchStall", 32'(fetchStall), 1);
    step(1);
    memConflict = 0;
    check("R4 stages", 32'(stageValid), 32'h1e);
    check("R4 tag held", 32'(fetchTag), 4);
  endtask

  task automatic testClashIgnored();
    doReset();
    fetchReady = 1; memConflict = 1;
    #1;
    check("R5 fetchEn", 32'(fetchEn), 1);
    step(1);
    memConflict = 0;
    check("R5 fetched", 32'(stageValid), 32'h01);
    check("R5 tag", 32'(fetchTag), 1);
  endtask

  task automatic testBranch();
    doReset();
    fetchReady = 1;
    step(8);
    branchTaken = 1; branchTarget = 8'h40;
    #1;
    check("R6 redirect", 32'(redirect), 1);
    check("R6 redirectTag", 32'(redirectTag), 32'h40);
    step(1);
    branchTaken = 0;
    check("R7 flushed", 32'(stageValid), 32'h20);
    check("R7 target loaded", 32'(fetchTag), 32'h40);
    check("R7 branch in wb", 32'(wbTag), 3);
    step(1);
    check("R7 refill", 32'(stageValid), 32'h01);
    check("R7 tag after", 32'(fetchTag), 32'h41);
    step(5);
    check("R7 target at wb", 32'(wbTag), 32'h40);
    check("R9 retired after branch", 32'(retiredCount), 4);
    check("R9 cycles after branch", 32'(cycleCount), 15);
  endtask

  task automatic testBranchIgnored();
    doReset();
    fetchReady = 1; branchTaken = 1; branchTarget = 8'h77;
    #1;
    check("R8 no redirect", 32'(redirect), 0);
    step(1);
    branchTaken = 0;
    check("R8 tag counts", 32'(fetchTag), 1);
    check("R8 stages", 32'(stageValid), 32'h01);
  endtask

  initial begin
    testReset();
    testFill();
    testBubble();
    testClash();
    testClashIgnored();
    testBranch();
    testBranchIgnored();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule